// File: doc/BRIEF.md
# Machine-Mode Interrupt Control and Status Unit

This unit keeps the machine-mode interrupt state of a small RISC-V style core. It holds the global interrupt enable and its saved copy, the per-source enable register and the trap cause register. It also offers a read-only view of the pending interrupt request lines. A core reaches these registers through a plain CSR port. The port carries a 12-bit address, write data, a two-bit operation code (write, set bits, clear bits) and a combinational read data bus.

Three request lines come in: software, timer and external. In every cycle the unit masks them with the per-source enables and the global enable. When an interrupt is taken, the unit saves the global enable, clears it, records the cause and pulses a trap output for one cycle so that the core can redirect fetch. A return-from-trap pulse restores the global enable from the saved copy. Only machine mode exists, so the previous-privilege field always reads as machine mode.

Top module: `mirq_csr_unit`

## Requirements
- R1: After reset the status register (address 0x300) reads 0x0000_1800, the enable register (0x304) and the cause register (0x342) read 0, and trap_o is low.
- R2: The pending view (0x344) shows the software line at bit 3, the timer line at bit 7 and the external line at bit 11, in the same cycle the line changes, with all other bits zero. CSR writes to this address have no effect.
- R3: csr_op encodes 00 = none, 01 = write, 10 = set bits (old OR data), 11 = clear bits (old AND NOT data). Addresses 0x300, 0x304, 0x342 and 0x344 are mapped, and any other address reads 0.
- R4: In the enable register only bits 3 (software), 7 (timer) and 11 (external) are writable. All other bits read 0.
- R5: In the status register only bit 3 (global enable) and bit 7 (saved enable) are writable. Bits 12:11 always read 3, and all other bits read 0.
- R6: trap_o rises in the cycle after a clock edge at which the global enable is 1 and some pending bit has its enable bit set. Per-source enables alone, with the global enable at 0, never cause a trap.
- R7: On trap entry the saved enable takes the old global enable and the global enable clears. The cause register becomes 0x8000_0000 OR the index of the source taken (3, 7 or 11), and trap_cause_o carries that value while trap_o is high. A software trap taken with only the global enable set leaves the status register at 0x0000_1880.
- R8: When several enabled sources are pending at once, external (11) wins over software (3), and software wins over timer (7).
- R9: trap_o is high for one cycle only. No further trap is taken until the global enable is set again.
- R10: On mret_i the global enable takes the saved enable and the saved enable becomes 1.
- R11: Trap entry takes precedence over an mret_i pulse and over a CSR write to the status or cause register in the same cycle. An enable-register write in that cycle still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | CSR operation: none, write, set, clear |
| csr_wdata | input | 32 | CSR write or mask data |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| irq_soft | input | 1 | Software interrupt request line |
| irq_timer | input | 1 | Timer interrupt request line |
| irq_ext | input | 1 | External interrupt request line |
| mret_i | input | 1 | Return-from-trap pulse |
| trap_o | output | 1 | One-cycle pulse: interrupt taken |
| trap_cause_o | output | 32 | Cause of the interrupt taken |

## Verification
The hardest case to reach is a trap entry that falls on the same edge as an mret pulse and a status-register write. The global enable must be 1 and an enabled line must be pending just as the core tries to change the very bits that trap entry overwrites. The bench reaches it on purpose: it first arms the global and per-source enables with the lines held low, then raises a line in the same cycle as the conflicting write and return pulse. Random cycles also hit many other overlaps of lines, operations and returns, and each one is scored against a bench model of the register state.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   localparam int unsigned SRC_SOFT  = 3;
   localparam int unsigned SRC_TIMER = 7;
   localparam int unsigned SRC_EXT   = 11;

   localparam int unsigned ST_GIE    = 3;
   localparam int unsigned ST_SAVED  = 7;
   localparam int unsigned ST_PRIV   = 11;

   localparam int unsigned CODE_W    = 4;

   localparam logic [CODE_W-1:0] CODE_SOFT  = CODE_W'(SRC_SOFT);
   localparam logic [CODE_W-1:0] CODE_TIMER = CODE_W'(SRC_TIMER);
   localparam logic [CODE_W-1:0] CODE_EXT   = CODE_W'(SRC_EXT);

endpackage

// File: rtl/mirq_enable.sv
module mirq_enable
   import mirq_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter bit          HAS_EXT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  csr_op_e         op,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] en_q
);

   localparam logic [XLEN-1:0] BASE_MASK =
      (XLEN'(1) << SRC_SOFT) | (XLEN'(1) << SRC_TIMER);

   logic [XLEN-1:0] wmask;
   logic [XLEN-1:0] en_next;

   generate
      if (HAS_EXT) begin : g_ext
         assign wmask = BASE_MASK | (XLEN'(1) << SRC_EXT);
      end else begin : g_noext
         assign wmask = BASE_MASK;
      end
   endgenerate

   always_comb begin
      case (op)
         OP_WRITE: en_next = wdata;
         OP_SET:   en_next = en_q | wdata;
         OP_CLEAR: en_next = en_q & ~wdata;
         default:  en_next = en_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= en_next & wmask;
      end
   end

   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(en_q)) else $error("enable changed without write"); // R4

endmodule

// File: rtl/mirq_status.sv
module mirq_status
   import mirq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       mret,
   input  logic       wr_en,
   input  csr_op_e    op,
   input  logic [1:0] wbits,
   output logic       gie_q,
   output logic       saved_q
);

   logic [1:0] cur;
   logic [1:0] upd;

   assign cur = {saved_q, gie_q};

   always_comb begin
      case (op)
         OP_WRITE: upd = wbits;
         OP_SET:   upd = cur | wbits;
         OP_CLEAR: upd = cur & ~wbits;
         default:  upd = cur;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gie_q   <= 1'b0;
         saved_q <= 1'b0;
      end else if (take) begin
         saved_q <= gie_q;
         gie_q   <= 1'b0;
      end else if (mret) begin
         gie_q   <= saved_q;
         saved_q <= 1'b1;
      end else if (wr_en) begin
         gie_q   <= upd[0];
         saved_q <= upd[1];
      end
   end

   AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (!gie_q && (saved_q == $past(gie_q)))) else $error("entry save"); // R7
   AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      (mret && !take) |=> (saved_q && (gie_q == $past(saved_q)))) else $error("mret restore"); // R10

endmodule

// File: rtl/mirq_arbiter.sv
module mirq_arbiter
   import mirq_pkg::*;
#(
   parameter bit HAS_EXT = 1'b1
) (
   input  logic [2:0]        pend,
   output logic              any,
   output logic [CODE_W-1:0] code
);

   logic [2:0] grant;

   generate
      if (HAS_EXT) begin : g_ext
         always_comb begin
            grant    = '0;
            grant[2] = pend[2];
            grant[0] = pend[0] & ~pend[2];
            grant[1] = pend[1] & ~pend[0] & ~pend[2];
         end
      end else begin : g_noext
         always_comb begin
            grant    = '0;
            grant[0] = pend[0];
            grant[1] = pend[1] & ~pend[0];
         end
      end
   endgenerate

   assign any = |grant;

   always_comb begin
      code = CODE_TIMER;
      if (grant[2]) code = CODE_EXT;
      else if (grant[0]) code = CODE_SOFT;
   end

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(grant)) else $error("multiple grants"); // R8
   end

endmodule

// File: rtl/mirq_csr_unit.sv
module mirq_csr_unit
   import mirq_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned AW          = 12,
   parameter bit          HAS_EXT     = 1'b1,
   parameter logic [11:0] ADDR_STATUS = 12'h300,
   parameter logic [11:0] ADDR_ENABLE = 12'h304,
   parameter logic [11:0] ADDR_CAUSE  = 12'h342,
   parameter logic [11:0] ADDR_PEND   = 12'h344
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   csr_addr,
   input  logic [1:0]      csr_op,
   input  logic [XLEN-1:0] csr_wdata,
   output logic [XLEN-1:0] csr_rdata,
   input  logic            irq_soft,
   input  logic            irq_timer,
   input  logic            irq_ext,
   input  logic            mret_i,
   output logic            trap_o,
   output logic [XLEN-1:0] trap_cause_o
);

   localparam int unsigned PAD_W = XLEN - 1 - CODE_W;

   generate
      if (XLEN < 16) begin : g_bad_xlen
         $error("XLEN must be at least 16");
      end
      if (AW != 12) begin : g_bad_aw
         $error("AW must be 12");
      end
   endgenerate

   csr_op_e         op;
   logic            wr_any;
   logic            wr_status;
   logic            wr_enable;
   logic            wr_cause;
   logic [XLEN-1:0] pend_view;
   logic [XLEN-1:0] en_q;
   logic [XLEN-1:0] status_view;
   logic [XLEN-1:0] cause_q;
   logic [XLEN-1:0] cause_next;
   logic            gie_q;
   logic            saved_q;
   logic [2:0]      pend3;
   logic            any;
   logic [CODE_W-1:0] code;
   logic            take;
   logic            trap_q;
   logic            ext_line;

   assign op        = csr_op_e'(csr_op);
   assign wr_any    = (op != OP_NONE);
   assign wr_status = wr_any && (csr_addr == ADDR_STATUS);
   assign wr_enable = wr_any && (csr_addr == ADDR_ENABLE);
   assign wr_cause  = wr_any && (csr_addr == ADDR_CAUSE);

   generate
      if (HAS_EXT) begin : g_ext_line
         assign ext_line = irq_ext;
      end else begin : g_no_ext_line
         assign ext_line = 1'b0;
      end
   endgenerate

   always_comb begin
      pend_view            = '0;
      pend_view[SRC_SOFT]  = irq_soft;
      pend_view[SRC_TIMER] = irq_timer;
      pend_view[SRC_EXT]   = ext_line;
   end

   assign pend3 = {pend_view[SRC_EXT]   & en_q[SRC_EXT],
                   pend_view[SRC_TIMER] & en_q[SRC_TIMER],
                   pend_view[SRC_SOFT]  & en_q[SRC_SOFT]};

   mirq_enable #(
      .XLEN    (XLEN),
      .HAS_EXT (HAS_EXT)
   ) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_enable),
      .op    (op),
      .wdata (csr_wdata),
      .en_q  (en_q)
   );

   mirq_arbiter #(
      .HAS_EXT (HAS_EXT)
   ) u_arb (
      .pend (pend3),
      .any  (any),
      .code (code)
   );

   assign take = gie_q && any;

   mirq_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .mret    (mret_i),
      .wr_en   (wr_status),
      .op      (op),
      .wbits   ({csr_wdata[ST_SAVED], csr_wdata[ST_GIE]}),
      .gie_q   (gie_q),
      .saved_q (saved_q)
   );

   always_comb begin
      status_view              = '0;
      status_view[ST_GIE]      = gie_q;
      status_view[ST_SAVED]    = saved_q;
      status_view[ST_PRIV]     = 1'b1;
      status_view[ST_PRIV + 1] = 1'b1;
   end

   always_comb begin
      case (op)
         OP_WRITE: cause_next = csr_wdata;
         OP_SET:   cause_next = cause_q | csr_wdata;
         OP_CLEAR: cause_next = cause_q & ~csr_wdata;
         default:  cause_next = cause_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         trap_q  <= 1'b0;
      end else begin
         trap_q <= take;
         if (take) begin
            cause_q <= {1'b1, {PAD_W{1'b0}}, code};
         end else if (wr_cause) begin
            cause_q <= cause_next;
         end
      end
   end

   always_comb begin
      if (csr_addr == ADDR_STATUS)      csr_rdata = status_view;
      else if (csr_addr == ADDR_ENABLE) csr_rdata = en_q;
      else if (csr_addr == ADDR_CAUSE)  csr_rdata = cause_q;
      else if (csr_addr == ADDR_PEND)   csr_rdata = pend_view;
      else                              csr_rdata = '0;
   end

   assign trap_o       = trap_q;
   assign trap_cause_o = cause_q;

   AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |=> !trap_o) else $error("trap longer than one cycle"); // R9
   AST_TRAP_GIE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> !gie_q) else $error("global enable left on at trap"); // R9
   AST_NO_TRAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q |=> !trap_o) else $error("trap with global enable off"); // R6
   AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> trap_cause_o[XLEN-1]) else $error("cause missing interrupt flag"); // R7

endmodule

// File: tb/mirq_csr_unit_test.sv
module mirq_csr_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [1:0]  csr_op = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        irq_soft = 1'b0;
   logic        irq_timer = 1'b0;
   logic        irq_ext = 1'b0;
   logic        mret_i = 1'b0;
   logic        trap_o;
   logic [31:0] trap_cause_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model of the register state
   bit          m_gie = 1'b0;
   bit          m_saved = 1'b0;
   logic [31:0] m_en = '0;
   logic [31:0] m_cause = '0;
   bit          m_trap = 1'b0;

   always #10 clk = ~clk;

   mirq_csr_unit uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .csr_addr     (csr_addr),
      .csr_op       (csr_op),
      .csr_wdata    (csr_wdata),
      .csr_rdata    (csr_rdata),
      .irq_soft     (irq_soft),
      .irq_timer    (irq_timer),
      .irq_ext      (irq_ext),
      .mret_i       (mret_i),
      .trap_o       (trap_o),
      .trap_cause_o (trap_cause_o)
   );

   function automatic logic [31:0] apply_op(logic [1:0] op, logic [31:0] old, logic [31:0] d);
      case (op)
         2'b01:   return d;
         2'b10:   return old | d;
         2'b11:   return old & ~d;
         default: return old;
      endcase
   endfunction

   function automatic logic [31:0] pend_of(bit s, bit t, bit e);
      return (32'(s) << 3) | (32'(t) << 7) | (32'(e) << 11);
   endfunction

   function automatic logic [31:0] status_of(bit g, bit p);
      return 32'h1800 | (32'(p) << 7) | (32'(g) << 3);
   endfunction

   function automatic logic [31:0] exp_read(logic [11:0] a);
      case (a)
         12'h300: return status_of(m_gie, m_saved);
         12'h304: return m_en;
         12'h342: return m_cause;
         12'h344: return pend_of(irq_soft, irq_timer, irq_ext);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [11:0] a);
      case (a)
         12'h300: return "R5";
         12'h304: return "R4";
         12'h342: return "R7";
         12'h344: return "R2";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // advance the model by one clock edge using the inputs now applied
   task automatic model_step();
      logic [31:0] pend;
      logic [31:0] sv;
      bit          take;
      logic [3:0]  code;
      pend = pend_of(irq_soft, irq_timer, irq_ext) & m_en;
      take = m_gie && (pend != 0);
      code = pend[11] ? 4'd11 : (pend[3] ? 4'd3 : 4'd7);
      sv   = apply_op(csr_op, status_of(m_gie, m_saved), csr_wdata);
      if (take) begin
         m_cause = 32'h8000_0000 | 32'(code);
      end else if (csr_op != 2'b00 && csr_addr == 12'h342) begin
         m_cause = apply_op(csr_op, m_cause, csr_wdata);
      end
      if (take) begin
         m_saved = m_gie;
         m_gie   = 1'b0;
      end else if (mret_i) begin
         m_gie   = m_saved;
         m_saved = 1'b1;
      end else if (csr_op != 2'b00 && csr_addr == 12'h300) begin
         m_gie   = sv[3];
         m_saved = sv[7];
      end
      if (csr_op != 2'b00 && csr_addr == 12'h304) begin
         m_en = apply_op(csr_op, m_en, csr_wdata) & 32'h0000_0888;
      end
      m_trap = take;
   endtask

   // one full cycle: drive at negedge, check read, clock, check trap outputs
   task automatic cycle(logic [11:0] a, logic [1:0] op, logic [31:0] d,
                        bit s, bit t, bit e, bit r);
      @(negedge clk);
      csr_addr = a; csr_op = op; csr_wdata = d;
      irq_soft = s; irq_timer = t; irq_ext = e; mret_i = r;
      #1;
      chk(tag_of(a), csr_rdata, exp_read(a));
      model_step();
      @(posedge clk);
      #1;
      chk("R6", 32'(trap_o), 32'(m_trap));
      if (m_trap) chk("R7", trap_cause_o, m_cause);
   endtask

   task automatic idle();
      cycle(12'h000, 2'b00, 32'h0, irq_soft, irq_timer, irq_ext, 1'b0);
   endtask

   // read without a clock edge
   task automatic peek(logic [11:0] a, string req, logic [31:0] exp);
      @(negedge clk);
      csr_addr = a; csr_op = 2'b00; mret_i = 1'b0;
      #1;
      chk(req, csr_rdata, exp);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1", 32'(trap_o), 32'h0);
      peek(12'h300, "R1", 32'h0000_1800);
      peek(12'h304, "R1", 32'h0);
      peek(12'h342, "R1", 32'h0);

      // R2 live pending view, writes ignored
      cycle(12'h344, 2'b00, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
      peek(12'h344, "R2", 32'h0000_0008);
      cycle(12'h344, 2'b00, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
      peek(12'h344, "R2", 32'h0000_0888);
      cycle(12'h344, 2'b01, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0);
      peek(12'h344, "R2", 32'h0000_0080);
      cycle(12'h344, 2'b01, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R4 enable mask, R3 op encodings
      cycle(12'h304, 2'b01, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
      peek(12'h304, "R4", 32'h0000_0888);
      cycle(12'h304, 2'b11, 32'h0000_0080, 1'b0, 1'b0, 1'b0, 1'b0);
      peek(12'h304, "R3", 32'h0000_0808);
      cycle(12'h304, 2'b10, 32'h0000_0080, 1'b0, 1'b0, 1'b0, 1'b0);
      peek(12'h304, "R3", 32'h0000_0888);
      peek(12'h305, "R3", 32'h0);
      // R5 status mask
      cycle(12'h300, 2'b01, 32'hFFFF_E777, 1'b0, 1'b0, 1'b0, 1'b0);
      peek(12'h300, "R5", 32'h0000_1800);
      cycle(12'h304, 2'b01, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R6 per-source enable alone with line pending: no trap
      cycle(12'h304, 2'b01, 32'h8, 1'b1, 1'b0, 1'b0, 1'b0);
      repeat (3) idle();
      chk("R6", 32'(trap_o), 32'h0);
      cycle(12'h304, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      cycle(12'h300, 2'b10, 32'h8, 1'b0, 1'b0, 1'b0, 1'b0);
      idle();
      chk("R6", 32'(trap_o), 32'h0);
      // raise software line: trap
      cycle(12'h000, 2'b00, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R6", 32'(trap_o), 32'h1);
      chk("R7", trap_cause_o, 32'h8000_0003);
      peek(12'h300, "R7", 32'h0000_1880);
      // R9 single pulse while line stays high
      idle();
      chk("R9", 32'(trap_o), 32'h0);
      idle();
      chk("R9", 32'(trap_o), 32'h0);
      // R10 return, line dropped
      cycle(12'h000, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
      peek(12'h300, "R10", 32'h0000_1888);

      // R8 priority
      cycle(12'h304, 2'b01, 32'h888, 1'b0, 1'b0, 1'b0, 1'b0);
      cycle(12'h000, 2'b00, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0);
      chk("R8", trap_cause_o, 32'h8000_000B);
      cycle(12'h000, 2'b00, 32'h0, 1'b1, 1'b1, 1'b0, 1'b1);
      idle();
      chk("R8", trap_cause_o, 32'h8000_0003);
      cycle(12'h000, 2'b00, 32'h0, 1'b0, 1'b1, 1'b0, 1'b1);
      idle();
      chk("R8", trap_cause_o, 32'h8000_0007);
      cycle(12'h000, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);

      // R11 trap beats mret and status/cause writes
      peek(12'h300, "R11", 32'h0000_1888);
      cycle(12'h300, 2'b01, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1);
      chk("R11", 32'(trap_o), 32'h1);
      peek(12'h300, "R11", 32'h0000_1880);
      cycle(12'h304, 2'b11, 32'h800, 1'b0, 1'b0, 1'b0, 1'b1);
      cycle(12'h342, 2'b01, 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0);
      peek(12'h342, "R11", 32'h1234_5678);
      cycle(12'h342, 2'b01, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R11", trap_cause_o, 32'h8000_0007);
      cycle(12'h000, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);

      // clear enables, raise line: pending visible, no trap
      cycle(12'h304, 2'b01, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      cycle(12'h344, 2'b00, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
      chk("R6", 32'(trap_o), 32'h0);
      peek(12'h344, "R2", 32'h0000_0008);
      cycle(12'h344, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);

      // constrained random traffic
      for (int i = 0; i < 600; i++) begin
         logic [11:0] a;
         logic [1:0]  op;
         logic [31:0] d;
         int unsigned sel;
         sel = $urandom_range(0, 4);
         case (sel)
            0: a = 12'h300;
            1: a = 12'h304;
            2: a = 12'h342;
            3: a = 12'h344;
            default: a = 12'($urandom_range(0, 4095));
         endcase
         op = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         d  = ($urandom_range(0, 1) == 0) ? $urandom() : (32'h888 & $urandom());
         cycle(a, op, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule